// File: doc/BRIEF.md
# Serial-Loaded Two-Channel Attenuator Wiper Register

This block receives a 16-bit control word over a three-line serial link (a frame strobe, a serial clock and a data line) and turns it into the wiper settings of a two-channel stepped attenuator. The strobe going high opens a frame. Each rising edge of the serial clock during the frame moves one data bit into a shift register, least significant bit first. When the strobe drops, the received word is applied to the two channel registers. This happens only if the frame held exactly sixteen clock edges.

All three serial lines are asynchronous to the system clock. Each line passes through a synchronizer, and its edges are found in the system-clock domain. The system clock must therefore run at least four times faster than the serial clock. Each channel drives three outputs: a 6-bit tap position, a mute flag, and an effective tap that drops to the bottom of the range while the channel is muted. Together these give 65 distinct settings per channel. A one-cycle pulse reports each accepted frame. A separate one-cycle pulse reports each rejected frame.

Top module: `dual_tap_serial_ctrl`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, every channel reads tap position 0 with mute set (ch_mute_o all ones, ch_pos_o and ch_eff_o zero). update_o and err_o are low.
- R2: Word bits travel least significant first. Word bits 5:0 set channel 0's position and bit 6 is channel 0's mute. Bit 7 has no effect on any output.
- R3: Word bits 13:8 set channel 1's position and bit 14 is channel 1's mute. Bit 15 has no effect on any output.
- R4: A channel's effective tap equals its position while its mute flag is 0, and equals 0 while its mute flag is 1.
- R5: A frame of exactly 16 rising serial-clock edges changes the outputs only after the strobe falls. It produces exactly one update_o pulse, one system cycle long. The outputs change on no other occasion.
- R6: A frame with fewer or more than 16 rising serial-clock edges leaves every output as it was. It produces exactly one err_o pulse, one cycle long, and no update_o pulse.
- R7: Serial clock and data activity while the strobe is low changes no output and produces no pulse.
- R8: Each rising strobe restarts the bit count and clears the shift register, so a full frame after a rejected one is applied correctly.
- R9: update_o and err_o are never high together, and neither stays high for two cycles in a row.
- R10: While the strobe is still high, the outputs keep their previous values, even after the sixteenth bit has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en_i | input | 1 | Frame strobe, high during a frame |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| ch_pos_o | output | 12 | Tap positions, channel c at bits 6c+5:6c |
| ch_mute_o | output | 2 | Mute flags, bit c for channel c |
| ch_eff_o | output | 12 | Effective taps (0 when muted), same layout as ch_pos_o |
| update_o | output | 1 | One-cycle pulse when a frame is applied |
| err_o | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
Several words are sent, each chosen to show a different fault. Distinct non-symmetric positions in the two channels expose swapped fields or a reversed bit order. A repeat word that flips only bits 7 and 15 must leave the outputs alone, which shows that the don't-care bits are really ignored. A word that mutes one channel with a nonzero position separates the mute floor from the stored position. Frames of 15 and 17 edges, clock toggling with the strobe low, a check taken before the strobe falls, and a full frame sent right after a rejected one each test the frame-acceptance rule from a different side.

// File: rtl/dtap_pkg.sv
package dtap_pkg;
   typedef enum logic [1:0] {
      FR_NONE  = 2'd0,
      FR_LOAD  = 2'd1,
      FR_FAULT = 2'd2
   } frame_res_e;
endpackage

// File: rtl/dtap_sync.sv
module dtap_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dtap_frame_rx.sv
module dtap_frame_rx
   import dtap_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_s,
   input  logic              sck_s,
   input  logic              dat_s,
   output logic [WORD_W-1:0] word_o,
   output frame_res_e        res_o
);
   localparam int CNT_MAX = WORD_W + 1;
   localparam int CNT_W   = $clog2(WORD_W + 2);

   logic             en_d, sck_d;
   logic [CNT_W-1:0] bit_cnt;
   logic [WORD_W-1:0] shreg;
   logic             en_rise, en_fall, sck_rise;

   assign en_rise  = en_s & ~en_d;
   assign en_fall  = ~en_s & en_d;
   assign sck_rise = en_s & sck_s & ~sck_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_d    <= 1'b0;
         sck_d   <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
      end else begin
         en_d  <= en_s;
         sck_d <= sck_s;
         if (en_rise) begin
            bit_cnt <= '0;
            shreg   <= '0;
         end else if (sck_rise) begin
            shreg <= {dat_s, shreg[WORD_W-1:1]};
            if (bit_cnt != CNT_W'(CNT_MAX))
               bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   always_comb begin
      res_o = FR_NONE;
      if (en_fall)
         res_o = (bit_cnt == CNT_W'(WORD_W)) ? FR_LOAD : FR_FAULT;
   end

   assign word_o = shreg;
endmodule

// File: rtl/dtap_chan_reg.sv
module dtap_chan_reg #(
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             mute_i,
   output logic [POS_W-1:0] pos_o,
   output logic             mute_o,
   output logic [POS_W-1:0] eff_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pos_o  <= '0;
         mute_o <= 1'b1;
      end else if (load_i) begin
         pos_o  <= pos_i;
         mute_o <= mute_i;
      end
   end

   assign eff_o = mute_o ? '0 : pos_o;
endmodule

// File: rtl/dual_tap_serial_ctrl.sv
module dual_tap_serial_ctrl
   import dtap_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int POS_W       = 6,
   parameter int FIELD_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ser_en_i,
   input  logic                    ser_clk_i,
   input  logic                    ser_dat_i,
   output logic [NUM_CH*POS_W-1:0] ch_pos_o,
   output logic [NUM_CH-1:0]       ch_mute_o,
   output logic [NUM_CH*POS_W-1:0] ch_eff_o,
   output logic                    update_o,
   output logic                    err_o
);
   localparam int WORD_W   = NUM_CH * FIELD_W;
   localparam int MUTE_BIT = POS_W;

   generate
      if (FIELD_W < POS_W + 1) begin : g_bad_field
         $error("FIELD_W must hold the position and the mute bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic [WORD_W-1:0] word;
   frame_res_e        res;
   logic              load;

   dtap_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d_i ({ser_dat_i, ser_clk_i, ser_en_i}),
      .q_o (sync_q)
   );

   dtap_frame_rx #(.WORD_W(WORD_W)) i_rx (
      .clk    (clk),
      .rst    (rst),
      .en_s   (sync_q[0]),
      .sck_s  (sync_q[1]),
      .dat_s  (sync_q[2]),
      .word_o (word),
      .res_o  (res)
   );

   assign load = (res == FR_LOAD);

   logic [NUM_CH*(FIELD_W-POS_W-1)+1-1:0] spare_unused;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dtap_chan_reg #(.POS_W(POS_W)) i_chan (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .pos_i  (word[c*FIELD_W +: POS_W]),
            .mute_i (word[c*FIELD_W + MUTE_BIT]),
            .pos_o  (ch_pos_o[c*POS_W +: POS_W]),
            .mute_o (ch_mute_o[c]),
            .eff_o  (ch_eff_o[c*POS_W +: POS_W])
         );
         if (FIELD_W > POS_W + 1) begin : g_spare
            assign spare_unused[c*(FIELD_W-POS_W-1) +: (FIELD_W-POS_W-1)] =
               word[c*FIELD_W + POS_W + 1 +: (FIELD_W-POS_W-1)];
         end
      end
   endgenerate

   assign spare_unused[NUM_CH*(FIELD_W-POS_W-1)] = 1'b0;

   always_ff @(posedge clk) begin
      if (rst) begin
         update_o <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         update_o <= load;
         err_o    <= (res == FR_FAULT);
      end
   end
endmodule

// File: rtl/dtap_checker.sv
module dtap_checker #(
   parameter int NUM_CH = 2,
   parameter int POS_W  = 6
) (
   input logic                    clk,
   input logic                    rst,
   input logic [NUM_CH*POS_W-1:0] ch_pos_o,
   input logic [NUM_CH-1:0]       ch_mute_o,
   input logic [NUM_CH*POS_W-1:0] ch_eff_o,
   input logic                    update_o,
   input logic                    err_o
);
   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (ch_mute_o == '1 && ch_pos_o == '0 && ch_eff_o == '0
               && !update_o && !err_o));

   p_change_needs_update_r5: assert property (@(posedge clk) disable iff (rst)
      (!$stable(ch_pos_o) || !$stable(ch_mute_o)) |-> update_o);

   p_fault_holds_r6: assert property (@(posedge clk) disable iff (rst)
      err_o |-> ($stable(ch_pos_o) && $stable(ch_mute_o) && !update_o));

   p_pulses_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
      !(update_o && err_o));

   p_update_single_r9: assert property (@(posedge clk) disable iff (rst)
      update_o |=> !update_o);

   p_err_single_r9: assert property (@(posedge clk) disable iff (rst)
      err_o |=> !err_o);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_floor
         p_mute_floor_r4: assert property (@(posedge clk) disable iff (rst)
            ch_mute_o[c] |-> (ch_eff_o[c*POS_W +: POS_W] == '0));
         p_unmuted_pass_r4: assert property (@(posedge clk) disable iff (rst)
            !ch_mute_o[c] |-> (ch_eff_o[c*POS_W +: POS_W] == ch_pos_o[c*POS_W +: POS_W]));
      end
   endgenerate
endmodule

bind dual_tap_serial_ctrl dtap_checker #(.NUM_CH(NUM_CH), .POS_W(POS_W)) i_dtap_chk (
   .clk       (clk),
   .rst       (rst),
   .ch_pos_o  (ch_pos_o),
   .ch_mute_o (ch_mute_o),
   .ch_eff_o  (ch_eff_o),
   .update_o  (update_o),
   .err_o     (err_o)
);

// File: tb/test_dual_tap_serial_ctrl.sv
module test_dual_tap_serial_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [11:0] ch_pos, ch_eff;
   logic [1:0]  ch_mute;
   logic        update, err;

   int n_checks = 0, n_errors = 0;
   int upd_cnt = 0, err_cnt = 0;
   bit done = 0;

   logic [5:0] e_pos0 = 6'd0, e_pos1 = 6'd0;
   logic       e_m0 = 1'b1, e_m1 = 1'b1;

   always #10 clk = ~clk;

   dual_tap_serial_ctrl i_dual_tap_serial_ctrl (
      .clk (clk), .rst (rst),
      .ser_en_i (ser_en), .ser_clk_i (ser_clk), .ser_dat_i (ser_dat),
      .ch_pos_o (ch_pos), .ch_mute_o (ch_mute), .ch_eff_o (ch_eff),
      .update_o (update), .err_o (err)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (update) upd_cnt++;
         if (err)    err_cnt++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_outputs(input string req);
      check(req, {20'd0, ch_pos}, {20'd0, e_pos1, e_pos0});
      check(req, {30'd0, ch_mute}, {30'd0, e_m1, e_m0});
      check(req, {20'd0, ch_eff}, {20'd0, (e_m1 ? 6'd0 : e_pos1), (e_m0 ? 6'd0 : e_pos0)});
   endtask

   task automatic frame_open();
      ser_en = 1'b1;
      wait_cyc(8);
   endtask

   task automatic frame_bits(input logic [31:0] w, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         ser_dat = w[i];
         wait_cyc(6);
         ser_clk = 1'b1;
         wait_cyc(6);
         ser_clk = 1'b0;
      end
      wait_cyc(6);
   endtask

   task automatic frame_close();
      ser_en = 1'b0;
      wait_cyc(10);
   endtask

   task automatic apply_ok(input logic [15:0] w);
      e_pos0 = w[5:0];  e_m0 = w[6];
      e_pos1 = w[13:8]; e_m1 = w[14];
   endtask

   task automatic t_reset();
      check("R1 update", {31'd0, update}, 32'd0);
      check("R1 err", {31'd0, err}, 32'd0);
      check_outputs("R1 reset state");
   endtask

   task automatic t_basic();
      int u0 = upd_cnt, e0 = err_cnt;
      frame_open(); frame_bits(32'h15AA, 16); frame_close();
      apply_ok(16'h15AA);
      check_outputs("R2 R3 basic fields");
      check("R5 one update", upd_cnt - u0, 1);
      check("R5 no err", err_cnt - e0, 0);
   endtask

   task automatic t_dont_care();
      int u0 = upd_cnt;
      frame_open(); frame_bits(32'h952A, 16); frame_close();
      check_outputs("R2 R3 bits 7 and 15 ignored");
      check("R5 update on repeat", upd_cnt - u0, 1);
   endtask

   task automatic t_mute();
      frame_open(); frame_bits(32'h017F, 16); frame_close();
      apply_ok(16'h017F);
      check_outputs("R4 ch0 muted");
      frame_open(); frame_bits(32'h6A05, 16); frame_close();
      apply_ok(16'h6A05);
      check_outputs("R4 ch1 muted");
   endtask

   task automatic t_short_long();
      int u0 = upd_cnt, e0 = err_cnt;
      frame_open(); frame_bits(32'h0000, 15); frame_close();
      check_outputs("R6 short frame held");
      check("R6 short err", err_cnt - e0, 1);
      frame_open(); frame_bits(32'h1_3F3F, 17); frame_close();
      check_outputs("R6 long frame held");
      check("R6 long err", err_cnt - e0, 2);
      check("R6 no update", upd_cnt - u0, 0);
   endtask

   task automatic t_idle();
      int u0 = upd_cnt, e0 = err_cnt;
      frame_bits(32'hFFFF, 16);
      wait_cyc(10);
      check_outputs("R7 idle activity ignored");
      check("R7 no pulses", (upd_cnt - u0) + (err_cnt - e0), 0);
   endtask

   task automatic t_midframe();
      int u0 = upd_cnt;
      frame_open(); frame_bits(32'h0C33, 16);
      check_outputs("R10 held while strobe high");
      check("R10 no early update", upd_cnt - u0, 0);
      frame_close();
      apply_ok(16'h0C33);
      check_outputs("R10 applied after fall");
   endtask

   task automatic t_restart();
      int u0 = upd_cnt, e0 = err_cnt;
      frame_open(); frame_bits(32'h03FF, 10); frame_close();
      frame_open(); frame_bits(32'h2001, 16); frame_close();
      apply_ok(16'h2001);
      check_outputs("R8 frame after abort");
      check("R8 one err one update", (err_cnt - e0) * 16 + (upd_cnt - u0), 17);
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      wait_cyc(5);
      t_reset();
      rst = 1'b0;
      wait_cyc(3);
      t_reset();
      t_basic();
      t_dont_care();
      t_mute();
      t_short_long();
      t_idle();
      t_midframe();
      t_restart();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule